// File: doc/BRIEF.md
# Start-Up Delay Sequencer

This block keeps the core held off after power-on, after a reset request, and after a wake from power-down. It releases its `ready` output only once a start-up delay has run out. The delay is chosen by two select fields. A 4-bit clock-source code picks one of three oscillator kinds. A 2-bit start-up code then picks, for that source, a wake delay of either a short or a long count of clock cycles. On reset, it also picks a further millisecond wait of none, short or long.

A reset sequence runs three phases in a fixed order: the selected clock-cycle count, then a fixed 14-cycle count, then the millisecond wait. The millisecond wait is measured in pulses of a separate slow-tick input, with a parameter giving the ticks per millisecond. A wake sequence runs only the clock-cycle phase. An unknown select combination raises a flag, and the block then falls back to the longest delay.

Top module: `startup_delay_seq`

## Requirements
- R1: A reset sequence whose request is sampled at clock edge E0 raises `ready` at edge E0 + 1 + C + 14 + T. C is the decoded cycle count (SHORT_CYCLES or LONG_CYCLES). T is 0, MS_SHORT×TICKS_PER_MS or MS_LONG×TICKS_PER_MS, and it assumes a slow tick in every cycle of the wait. Once raised, `ready` stays high until a new request is accepted.
- R2: Source code 4'b0100 uses the short count for start-up codes 2'b00, 2'b01 and 2'b10, and the long count for 2'b11. Its reset waits are: 2'b00 none, 2'b01 short, 2'b10 long, 2'b11 none.
- R3: Source code 4'b0101 uses the long count for every start-up code. Its reset waits are: 2'b00 none, 2'b01 short, 2'b10 short, 2'b11 long.
- R4: Source code 4'b0001 uses the short count for start-up codes 2'b00, 2'b01 and 2'b10. Its reset waits are: 2'b00 none, 2'b01 short, 2'b10 long.
- R5: Every other combination, including 4'b0001 with 2'b11, is illegal. It sets `badCode` and uses the long cycle count with the long millisecond wait.
- R6: A wake request is accepted only while `ready` is high. `ready` drops at the next edge and rises again 1 + C edges after the request edge, with no 14-cycle phase and no millisecond wait.
- R7: The select fields are sampled only in the first cycle of a sequence. Changes later in the sequence, or while ready, do not alter the delay.
- R8: A reset request in any phase or while ready drops `ready` at the next edge and restarts the full sequence. When reset and wake are requested in the same cycle, the reset wins.
- R9: A wake request while a sequence is running is ignored and does not change its length.
- R10: The millisecond phase advances only on cycles with `slowTick` high. Without ticks, `ready` stays low.
- R11: `badCode` is updated only at the start of a sequence and holds its value until the next start.
- R12: While `rstN` is low, `ready` and `badCode` are low. Releasing `rstN` starts a reset sequence, timed as if the request had been sampled at the last edge before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being counted |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| slowTick | input | 1 | One-cycle pulse of the slow timebase |
| resetReq | input | 1 | Reset event request, starts a full sequence |
| wakeReq | input | 1 | Wake-from-power-down request |
| srcSel | input | 4 | Clock-source select code |
| sutSel | input | 2 | Start-up select code |
| ready | output | 1 | High once the start-up delay has elapsed |
| badCode | output | 1 | Select combination of the current sequence was illegal |

## Verification
A reset request and a wake request can arrive in the same cycle, and the reset must take priority. The bench raises both on one edge while `ready` is high. It then expects the longer reset latency, not the wake latency. A reset request can also land in the middle of a running count, or in the cycle just after one has finished. The bench fires restarts during the cycle phase and during the millisecond wait, then checks that `ready` falls at once and that the stale expectation is discarded. It then measures the new sequence from the restart edge.

// File: rtl/sus_pkg.sv
package sus_pkg;

  localparam logic [3:0] SRC_CRYSTAL = 4'b0100;
  localparam logic [3:0] SRC_EXTCLK  = 4'b0101;
  localparam logic [3:0] SRC_RCOSC   = 4'b0001;

  typedef enum logic [1:0] {
    WAIT_NONE  = 2'd0,
    WAIT_SHORT = 2'd1,
    WAIT_LONG  = 2'd2
  } msWaitT;

  typedef enum logic [2:0] {
    ST_LOAD = 3'd0,
    ST_CYC  = 3'd1,
    ST_FIX  = 3'd2,
    ST_MS   = 3'd3,
    ST_DONE = 3'd4
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // sample selects, load the cycle count
    logic loadFix;   // load the fixed reset count
    logic loadMs;    // load the millisecond tick count
    logic decrement; // count down by one
  } strobeT;

endpackage

// File: rtl/sus_decode.sv
module sus_decode
  import sus_pkg::*;
(
  input  logic [3:0] srcSel,
  input  logic [1:0] sutSel,
  output logic       useLong,
  output msWaitT     msWait,
  output logic       illegal
);

  always_comb begin
    useLong = 1'b1;
    msWait  = WAIT_LONG;
    illegal = 1'b0;
    unique case (srcSel)
      SRC_CRYSTAL: begin
        useLong = (sutSel == 2'b11);
        unique case (sutSel)
          2'b01:   msWait = WAIT_SHORT;
          2'b10:   msWait = WAIT_LONG;
          default: msWait = WAIT_NONE;
        endcase
      end
      SRC_EXTCLK: begin
        useLong = 1'b1;
        unique case (sutSel)
          2'b00:   msWait = WAIT_NONE;
          2'b11:   msWait = WAIT_LONG;
          default: msWait = WAIT_SHORT;
        endcase
      end
      SRC_RCOSC: begin
        unique case (sutSel)
          2'b00: begin useLong = 1'b0; msWait = WAIT_NONE;  end
          2'b01: begin useLong = 1'b0; msWait = WAIT_SHORT; end
          2'b10: begin useLong = 1'b0; msWait = WAIT_LONG;  end
          default: illegal = 1'b1;
        endcase
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sus_datapath.sv
module sus_datapath
  import sus_pkg::*;
#(
  parameter int SHORT_CYCLES = 1024,
  parameter int LONG_CYCLES  = 16384,
  parameter int FIXED_CYCLES = 14,
  parameter int TICKS_PER_MS = 32,
  parameter int MS_SHORT     = 4,
  parameter int MS_LONG      = 64
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT stb,
  input  logic   decUseLong,
  input  msWaitT decWait,
  input  logic   decIllegal,
  output logic   cntZero,
  output logic   cntOne,
  output logic   msNone,
  output logic   badCode
);

  localparam int MS_LONG_TICKS  = MS_LONG * TICKS_PER_MS;
  localparam int MS_SHORT_TICKS = MS_SHORT * TICKS_PER_MS;
  localparam int MAX_LOAD = (LONG_CYCLES > MS_LONG_TICKS) ? LONG_CYCLES : MS_LONG_TICKS;
  localparam int CW = $clog2(MAX_LOAD + 1);

  localparam logic [CW-1:0] LD_SHORT = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LD_LONG  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] LD_FIX   = CW'(FIXED_CYCLES - 1);
  localparam logic [CW-1:0] LD_MSS   = CW'(MS_SHORT_TICKS);
  localparam logic [CW-1:0] LD_MSL   = CW'(MS_LONG_TICKS);

  logic [CW-1:0] cnt;
  msWaitT        waitReg;
  logic          badReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      waitReg <= WAIT_NONE;
      badReg  <= 1'b0;
    end else if (stb.capture) begin
      cnt     <= decUseLong ? LD_LONG : LD_SHORT;
      waitReg <= decWait;
      badReg  <= decIllegal;
    end else if (stb.loadFix) begin
      cnt <= LD_FIX;
    end else if (stb.loadMs) begin
      cnt <= (waitReg == WAIT_LONG) ? LD_MSL : LD_MSS;
    end else if (stb.decrement) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == CW'(1));
  assign msNone  = (waitReg == WAIT_NONE);
  assign badCode = badReg;

endmodule

// File: rtl/sus_ctrl.sv
module sus_ctrl
  import sus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   resetReq,
  input  logic   wakeReq,
  input  logic   slowTick,
  input  logic   cntZero,
  input  logic   cntOne,
  input  logic   msNone,
  output strobeT stb,
  output logic   ready
);

  seqStateT state, stateNxt;
  logic     modeRst, modeRstNxt;

  always_comb begin
    stateNxt   = state;
    modeRstNxt = modeRst;
    stb        = '0;
    unique case (state)
      ST_LOAD: begin
        stb.capture = 1'b1;
        stateNxt    = ST_CYC;
      end
      ST_CYC: begin
        if (!cntZero) begin
          stb.decrement = 1'b1;
        end else if (modeRst) begin
          stb.loadFix = 1'b1;
          stateNxt    = ST_FIX;
        end else begin
          stateNxt = ST_DONE;
        end
      end
      ST_FIX: begin
        if (!cntZero) begin
          stb.decrement = 1'b1;
        end else if (msNone) begin
          stateNxt = ST_DONE;
        end else begin
          stb.loadMs = 1'b1;
          stateNxt   = ST_MS;
        end
      end
      ST_MS: begin
        if (slowTick) begin
          if (cntOne) stateNxt = ST_DONE;
          else        stb.decrement = 1'b1;
        end
      end
      ST_DONE: begin
        if (wakeReq) begin
          stateNxt   = ST_LOAD;
          modeRstNxt = 1'b0;
        end
      end
      default: stateNxt = ST_LOAD;
    endcase
    // a reset event overrides every phase and any wake in the same cycle
    if (resetReq) begin
      stateNxt   = ST_LOAD;
      modeRstNxt = 1'b1;
      stb        = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      modeRst <= 1'b1;
      ready   <= 1'b0;
    end else begin
      state   <= stateNxt;
      modeRst <= modeRstNxt;
      ready   <= (stateNxt == ST_DONE);
    end
  end

endmodule

// File: rtl/startup_delay_seq.sv
module startup_delay_seq
  import sus_pkg::*;
#(
  parameter int SHORT_CYCLES = 1024,
  parameter int LONG_CYCLES  = 16384,
  parameter int FIXED_CYCLES = 14,
  parameter int TICKS_PER_MS = 32,
  parameter int MS_SHORT     = 4,
  parameter int MS_LONG      = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic       resetReq,
  input  logic       wakeReq,
  input  logic [3:0] srcSel,
  input  logic [1:0] sutSel,
  output logic       ready,
  output logic       badCode
);

  strobeT stb;
  logic   decUseLong, decIllegal;
  msWaitT decWait;
  logic   cntZero, cntOne, msNone;

  sus_decode u_decode (
    .srcSel  (srcSel),
    .sutSel  (sutSel),
    .useLong (decUseLong),
    .msWait  (decWait),
    .illegal (decIllegal)
  );

  sus_datapath #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES),
    .FIXED_CYCLES (FIXED_CYCLES),
    .TICKS_PER_MS (TICKS_PER_MS),
    .MS_SHORT     (MS_SHORT),
    .MS_LONG      (MS_LONG)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .decUseLong (decUseLong),
    .decWait    (decWait),
    .decIllegal (decIllegal),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .msNone     (msNone),
    .badCode    (badCode)
  );

  sus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resetReq (resetReq),
    .wakeReq  (wakeReq),
    .slowTick (slowTick),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .msNone   (msNone),
    .stb      (stb),
    .ready    (ready)
  );

endmodule

// File: rtl/sus_checker.sv
module sus_checker #(
  parameter int SHORT_CYCLES = 1024
) (
  input logic clk,
  input logic rstN,
  input logic resetReq,
  input logic wakeReq,
  input logic ready,
  input logic badCode
);

  localparam int SW = $clog2(SHORT_CYCLES + 2) + 1;
  logic [SW-1:0] sinceStart;

  // cycles since the last accepted request, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= '0;
    else if (resetReq || (wakeReq && ready)) sinceStart <= '0;
    else if (sinceStart != {SW{1'b1}}) sinceStart <= sinceStart + 1'b1;
  end

  assert_reset_drops_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !ready);

  assert_wake_drops_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && ready && !resetReq) |=> !ready);

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !resetReq && !wakeReq) |=> ready);

  assert_flag_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> $stable(badCode));

  assert_min_delay_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (sinceStart >= SW'(SHORT_CYCLES)));

endmodule

bind startup_delay_seq sus_checker #(.SHORT_CYCLES(SHORT_CYCLES)) u_sus_checker (
  .clk      (clk),
  .rstN     (rstN),
  .resetReq (resetReq),
  .wakeReq  (wakeReq),
  .ready    (ready),
  .badCode  (badCode)
);

// File: tb/startup_delay_seq_bench.sv
module startup_delay_seq_bench;

  localparam int SC  = 16;
  localparam int LC  = 40;
  localparam int FC  = 14;
  localparam int TPM = 3;

  logic       clk = 1'b0;
  logic       rstN, tickLvl, resetReq, wakeReq;
  logic [3:0] srcSel;
  logic [1:0] sutSel;
  wire        ready, badCode;

  always #5 clk = ~clk;

  startup_delay_seq #(
    .SHORT_CYCLES (SC), .LONG_CYCLES (LC), .FIXED_CYCLES (FC),
    .TICKS_PER_MS (TPM), .MS_SHORT (4), .MS_LONG (64)
  ) u_startup_delay_seq (
    .clk (clk), .rstN (rstN), .slowTick (tickLvl), .resetReq (resetReq),
    .wakeReq (wakeReq), .srcSel (srcSel), .sutSel (sutSel),
    .ready (ready), .badCode (badCode)
  );

  int cycNo = 0;
  always @(posedge clk) cycNo <= cycNo + 1;

  typedef struct {
    int    startCyc;
    int    lat;
    bit    bad;
    string tag;
  } itemT;
  itemT q[$];

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected latency from the request edge, per the requirement tables
  function automatic int expLat(bit wake, logic [3:0] s, logic [1:0] u, output bit bad);
    int cyc = LC;
    int ms  = 64;
    bad = 1'b0;
    case (s)
      4'b0100: begin cyc = (u == 2'b11) ? LC : SC; ms = (u == 2'b01) ? 4 : (u == 2'b10) ? 64 : 0; end
      4'b0101: begin cyc = LC; ms = (u == 2'b00) ? 0 : (u == 2'b11) ? 64 : 4; end
      4'b0001: begin
        if (u == 2'b11) bad = 1'b1;
        else begin cyc = SC; ms = (u == 2'b01) ? 4 : (u == 2'b10) ? 64 : 0; end
      end
      default: bad = 1'b1;
    endcase
    if (bad) begin cyc = LC; ms = 64; end
    return wake ? (1 + cyc) : (1 + cyc + FC + ms * TPM);
  endfunction

  // monitor: scoreboard pop on each rising edge of ready
  bit prevReady = 1'b0;
  always @(negedge clk) begin
    if (!rstN) prevReady = 1'b0;
    else begin
      if (ready && !prevReady) begin
        if (q.size() == 0) check(1'b0, "R1 unexpected ready", 1, 0);
        else begin
          itemT it;
          it = q.pop_front();
          check(cycNo - it.startCyc == it.lat, it.tag, cycNo - it.startCyc, it.lat);
          check(badCode == it.bad, {it.tag, " flag"}, badCode, it.bad);
        end
      end
      prevReady = ready;
    end
  end

  task automatic request(bit wake, logic [3:0] s, logic [1:0] u, string tag);
    itemT it;
    bit   b;
    @(negedge clk);
    srcSel = s; sutSel = u;
    it.lat = expLat(wake, s, u, b);
    it.bad = b; it.tag = tag; it.startCyc = cycNo + 1;
    if (!wake) q.delete();
    q.push_back(it);
    if (wake) wakeReq = 1'b1; else resetReq = 1'b1;
    @(negedge clk);
    resetReq = 1'b0; wakeReq = 1'b0;
    check(ready == 1'b0, {tag, " ready drop"}, ready, 0);
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic skip(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickLvl = 1'b1; resetReq = 1'b0; wakeReq = 1'b0;
    srcSel = 4'b0100; sutSel = 2'b01;
    skip(3);
    check(ready == 1'b0, "R12 ready in reset", ready, 0);
    check(badCode == 1'b0, "R12 flag in reset", badCode, 0);
    begin
      itemT it;
      bit   b;
      it.lat = expLat(1'b0, 4'b0100, 2'b01, b);
      it.bad = b; it.tag = "R12 power-on"; it.startCyc = cycNo;
      q.push_back(it);
      rstN = 1'b1;
    end
    waitIdle();

    // R2 crystal source, all start-up codes
    for (int u = 0; u < 4; u++) begin request(1'b0, 4'b0100, 2'(u), "R2 src0100 reset"); waitIdle(); end
    // R3 external clock
    for (int u = 0; u < 4; u++) begin request(1'b0, 4'b0101, 2'(u), "R3 src0101 reset"); waitIdle(); end
    // R4 RC oscillator legal codes
    for (int u = 0; u < 3; u++) begin request(1'b0, 4'b0001, 2'(u), "R4 src0001 reset"); waitIdle(); end
    // R5 illegal codes
    request(1'b0, 4'b0001, 2'b11, "R5 src0001/11 illegal"); waitIdle();
    request(1'b0, 4'b1111, 2'b00, "R5 src1111 illegal");    waitIdle();
    // R11 flag held while selects change idly
    srcSel = 4'b0100; sutSel = 2'b00;
    skip(5);
    check(badCode == 1'b1, "R11 flag held", badCode, 1);
    check(ready == 1'b1, "R7 ready held on select change", ready, 1);
    request(1'b0, 4'b0000, 2'b10, "R5 src0000 illegal"); waitIdle();
    request(1'b0, 4'b0100, 2'b00, "R11 flag clears");    waitIdle();

    // R6 wakes: cycle delay only
    request(1'b1, 4'b0100, 2'b10, "R6 wake src0100/10"); waitIdle();
    request(1'b1, 4'b0101, 2'b01, "R6 wake src0101/01"); waitIdle();
    request(1'b1, 4'b0100, 2'b11, "R6 wake src0100/11"); waitIdle();

    // R8 reset and wake in the same cycle: reset wins
    begin
      itemT it;
      bit   b;
      @(negedge clk);
      srcSel = 4'b0101; sutSel = 2'b01;
      it.lat = expLat(1'b0, 4'b0101, 2'b01, b);
      it.bad = b; it.tag = "R8 reset beats wake"; it.startCyc = cycNo + 1;
      q.push_back(it);
      resetReq = 1'b1; wakeReq = 1'b1;
      @(negedge clk);
      resetReq = 1'b0; wakeReq = 1'b0;
      check(ready == 1'b0, "R8 ready drop on joint request", ready, 0);
    end
    waitIdle();

    // R8 restart during the cycle phase and during the ms phase
    request(1'b0, 4'b0101, 2'b11, "R8 aborted");
    skip(10);
    request(1'b0, 4'b0001, 2'b00, "R8 restart in cycle phase"); waitIdle();
    request(1'b0, 4'b0100, 2'b10, "R8 aborted");
    skip(SC + FC + 20);
    check(ready == 1'b0, "R8 still in ms phase", ready, 0);
    request(1'b0, 4'b0100, 2'b01, "R8 restart in ms phase"); waitIdle();

    // R7 select change mid-sequence is ignored
    request(1'b0, 4'b0100, 2'b10, "R7 sel change ignored");
    skip(3);
    srcSel = 4'b0101; sutSel = 2'b11;
    skip(SC + 5);
    srcSel = 4'b1010; sutSel = 2'b00;
    waitIdle();

    // R9 wake during a running sequence is ignored
    request(1'b0, 4'b0001, 2'b01, "R9 wake ignored");
    skip(8);
    wakeReq = 1'b1; skip(1); wakeReq = 1'b0;
    skip(SC);
    wakeReq = 1'b1; skip(1); wakeReq = 1'b0;
    waitIdle();

    // R10 ms phase advances only on ticks
    begin
      itemT it;
      int   gap = 20;
      @(negedge clk);
      tickLvl = 1'b0; srcSel = 4'b0100; sutSel = 2'b01;
      it.lat = 1 + SC + FC + gap + 4 * TPM;
      it.bad = 1'b0; it.tag = "R10 tick gated"; it.startCyc = cycNo + 1;
      q.delete(); q.push_back(it);
      resetReq = 1'b1;
      @(negedge clk);
      resetReq = 1'b0;
      while (cycNo != it.startCyc + 1 + SC + FC + gap) @(negedge clk);
      check(ready == 1'b0, "R10 no progress without ticks", ready, 0);
      tickLvl = 1'b1;
    end
    waitIdle();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule